// File: doc/BRIEF.md
# Streamed Matrix-Vector Tile

This block is the shared matrix-vector engine of a small fixed-point Transformer datapath. It computes sixteen output rows at once. Each lane owns a read-only weight store, and a controller points the tile at a different region of those stores for each projection in turn: query, key, value, attention output, MLP up and down, and the vocabulary head. The matrix is never buffered. The input vector arrives one 16-bit element per cycle. For each element, every lane fetches the weight at the current column address, forms the product and adds it to its own wide accumulator.

A block starts with a single `start` pulse. That pulse captures the weight base address, the number of columns and the number of rows that are in use, and it clears all accumulators. After the last column has been taken, each accumulator is scaled back to the 16-bit signed fixed-point format with round-to-nearest and saturation. The sixteen results are then presented together under a valid/ready handshake, with a one-cycle `done` pulse. A new block may be started in the cycle right after the last column, so that consecutive projections follow each other without a gap.

Top module: `mv_tile`

## Requirements
- R1: Values are 16-bit two's complement with 12 fraction bits. Lane i outputs sat(round(sum over k of x[k]*W_i[a_k] / 4096)), where a_k is the weight address of column k. Each accumulator is 40 bits wide, so 64 products of full-scale operands cannot overflow it.
- R2: A column is consumed on every clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while a block is active and not stalled.
- R3: The weight address of column k is (base_addr + k) mod 128. The content of lane l's store at address a is bits [15:0] of (1237*a + 4099*l + 771), read as two's complement.
- R4: Rounding adds 2048 to the accumulator and then shifts it arithmetically right by 12, so that exact halves round toward positive infinity.
- R5: A rounded value above 32767 gives 32767, and a rounded value below -32768 gives -32768.
- R6: `out_valid` and `done` rise together one clock after the edge that accepts the last column. `done` lasts one cycle. Lane i is carried in `out_data[16*i+15:16*i]`.
- R7: Every lane whose index is at least `row_cnt` outputs zero.
- R8: A start that is accepted clears the accumulators. A start given in the cycle right after the last column is accepted, and columns of the new block are accepted from the next cycle on, while the previous result is presented.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values and `in_ready` is low.
- R10: A start is ignored while a block is active, and it is ignored when `vec_len` is 0 or greater than 64.
- R11: After reset, `busy`, `in_ready`, `out_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a row block |
| base_addr | input | 7 | Weight address of the first column |
| vec_len | input | 7 | Number of columns, 1 to 64 |
| row_cnt | input | 5 | Number of active lanes, 0 to 16 |
| in_valid | input | 1 | Input element is valid |
| in_data | input | 16 | Input vector element |
| in_ready | output | 1 | Tile accepts an element |
| out_valid | output | 1 | Results are available |
| out_ready | input | 1 | Consumer takes the results |
| out_data | output | 256 | Sixteen packed lane results |
| done | output | 1 | One-cycle pulse when the results appear |
| busy | output | 1 | A block is being accumulated |

## Verification
Inputs are driven on the falling edge and outputs are sampled on the following falling edge, so each value is read half a cycle after the rising edge that produced it. `in_ready` is due at the falling edge after the start edge. At the falling edge after the last column, `out_valid` must still be low. One falling edge later, `out_valid`, `done` and all sixteen lanes are checked against a model of the sum, rounding and saturation built in the bench. Under back-pressure and during back-to-back starts, the held result and the state of `in_ready` are checked on every falling edge of the stall.

// File: rtl/mv_tile.sv
module mv_tile #(
  parameter int LANES   = 16,
  parameter int DW      = 16,
  parameter int FRAC    = 12,
  parameter int ACC_W   = 40,
  parameter int MAX_LEN = 64,
  parameter int DEPTH   = 128,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int ADDR_W  = $clog2(DEPTH),
  parameter int ROW_W   = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [ADDR_W-1:0]   base_addr,
  input  logic [LEN_W-1:0]    vec_len,
  input  logic [ROW_W-1:0]    row_cnt,
  input  logic                in_valid,
  input  logic [DW-1:0]       in_data,
  output logic                in_ready,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [LANES*DW-1:0] out_data,
  output logic                done,
  output logic                busy
);

  localparam logic signed [ACC_W-1:0] HALF = {{(ACC_W-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] SMAX = {{(ACC_W-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SMIN = {{(ACC_W-DW+1){1'b1}}, {(DW-1){1'b0}}};

  function automatic logic [DW-1:0] wgen(input int l, input int a);
    logic [31:0] t;
    t = 32'(a) * 32'd1237 + 32'(l) * 32'd4099 + 32'd771;
    return t[DW-1:0];
  endfunction

  logic              busy_q, pend_q, ov_q, done_q;
  logic [LEN_W-1:0]  len_q, col_q;
  logic [ADDR_W-1:0] base_q, rd_addr;
  logic [ROW_W-1:0]  rows_q;
  logic              start_ok, take, last;

  assign start_ok = start && !busy_q && (vec_len != '0) && (vec_len <= LEN_W'(MAX_LEN));
  assign in_ready = busy_q && !(ov_q && !out_ready);
  assign take     = in_valid && in_ready;
  assign last     = take && (col_q == len_q - 1'b1);
  assign rd_addr  = base_q + ADDR_W'(col_q);
  assign out_valid = ov_q;
  assign done      = done_q;
  assign busy      = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      ov_q   <= 1'b0;
      done_q <= 1'b0;
      len_q  <= '0;
      col_q  <= '0;
      base_q <= '0;
      rows_q <= '0;
    end else begin
      done_q <= 1'b0;
      pend_q <= 1'b0;
      if (ov_q && out_ready) ov_q <= 1'b0;
      if (pend_q) begin
        ov_q   <= 1'b1;
        done_q <= 1'b1;
      end
      if (start_ok) begin
        busy_q <= 1'b1;
        base_q <= base_addr;
        len_q  <= vec_len;
        rows_q <= row_cnt;
        col_q  <= '0;
      end else if (take) begin
        col_q <= col_q + 1'b1;
        if (last) begin
          busy_q <= 1'b0;
          pend_q <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DW-1:0]              rom [DEPTH];
    logic signed [DW-1:0]       wt;
    logic signed [2*DW-1:0]     prod;
    logic signed [ACC_W-1:0]    acc_q, rsh;
    logic [DW-1:0]              sat, res_q;

    initial begin
      for (int a = 0; a < DEPTH; a++) rom[a] = wgen(g, a);
    end

    assign wt   = $signed(rom[rd_addr]);
    assign prod = wt * $signed(in_data);
    assign rsh  = (acc_q + HALF) >>> FRAC;
    assign sat  = (rsh > SMAX) ? SMAX[DW-1:0] :
                  (rsh < SMIN) ? SMIN[DW-1:0] : rsh[DW-1:0];

    always_ff @(posedge clk) begin
      if (!rst_n)        acc_q <= '0;
      else if (start_ok) acc_q <= '0;
      else if (take)     acc_q <= acc_q + {{(ACC_W-2*DW){prod[2*DW-1]}}, prod};
    end

    always_ff @(posedge clk) begin
      if (!rst_n)      res_q <= '0;
      else if (pend_q) res_q <= (rows_q > ROW_W'(g)) ? sat : '0;
    end

    assign out_data[g*DW +: DW] = res_q;
  end

endmodule

// File: rtl/mv_tile_chk.sv
module mv_tile_chk #(
  parameter int LANES = 16,
  parameter int DW    = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic                done,
  input logic [LANES*DW-1:0] out_data
);

  AST_READY_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy); // R2

  AST_DONE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_VALID_RISE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> done); // R6

  AST_RESULT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |=> (out_valid && done)); // R6

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9

endmodule

bind mv_tile mv_tile_chk #(.LANES(LANES), .DW(DW)) u_chk (.*);

// File: tb/sim_mv_tile.sv
`timescale 1ns/1ps
module sim_mv_tile;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [6:0]   base_addr = '0;
  logic [6:0]   vec_len = '0;
  logic [4:0]   row_cnt = '0;
  logic         in_valid = 1'b0;
  logic [15:0]  in_data = '0;
  logic         in_ready;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [255:0] out_data;
  logic         done;
  logic         busy;

  int nchk = 0;
  int nfail = 0;
  int xv [64];
  int exp_lane [16];

  always #4 clk = ~clk;

  mv_tile u0 (.*);

  function automatic int wgt(input int l, input int a);
    logic [31:0] t;
    t = 32'(a) * 32'd1237 + 32'(l) * 32'd4099 + 32'd771;
    return int'($signed(t[15:0]));
  endfunction

  function automatic void model(input int b, input int len, input int rows);
    for (int l = 0; l < 16; l++) begin
      longint acc = 0;
      longint r;
      for (int k = 0; k < len; k++) acc += longint'(xv[k]) * longint'(wgt(l, (b + k) % 128));
      r = (acc + 2048) >>> 12;
      if (r > 32767) r = 32767;
      if (r < -32768) r = -32768;
      exp_lane[l] = (l < rows) ? int'(r) : 0;
    end
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic check_lanes(input string req);
    for (int l = 0; l < 16; l++) begin
      int got = int'($signed(out_data[l*16 +: 16]));
      chk(got == exp_lane[l], req, $sformatf("lane %0d", l), got, exp_lane[l]);
    end
  endtask

  task automatic do_start(input int b, input int len, input int rows);
    @(negedge clk);
    start = 1'b1; base_addr = 7'(b); vec_len = 7'(len); row_cnt = 5'(rows);
    @(posedge clk);
    #1 start = 1'b0;
  endtask

  task automatic feed(input int from, input int to, input bit gap);
    for (int k = from; k < to; k++) begin
      if (gap && (k % 3 == 1)) begin
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
      end
      @(negedge clk);
      chk(in_ready == 1'b1, "R2", "in_ready while feeding", in_ready, 1);
      in_valid = 1'b1;
      in_data = 16'(xv[k]);
      @(posedge clk);
      #1 in_valid = 1'b0;
    end
  endtask

  task automatic wait_out(input string req);
    @(negedge clk);
    chk(out_valid == 1'b0, "R6", "out_valid not early", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R6", "out_valid on time", out_valid, 1);
    chk(done == 1'b1, "R6", "done with result", done, 1);
    check_lanes(req);
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(busy == 1'b0, "R11", "busy after reset", busy, 0);
    chk(in_ready == 1'b0, "R11", "in_ready after reset", in_ready, 0);
    chk(out_valid == 1'b0, "R11", "out_valid after reset", out_valid, 0);
    chk(done == 1'b0, "R11", "done after reset", done, 0);
  endtask

  task automatic t_basic;
    for (int k = 0; k < 16; k++) xv[k] = ((k * 97) % 601) - 300;
    model(0, 16, 16);
    do_start(0, 16, 16);
    feed(0, 16, 1'b0);
    wait_out("R1");
    @(negedge clk);
    chk(done == 1'b0, "R6", "done is one cycle", done, 0);
    chk(out_valid == 1'b0, "R6", "out_valid cleared after take", out_valid, 0);
  endtask

  task automatic t_round;
    xv[0] = 2048;
    model(5, 1, 16);
    do_start(5, 1, 16);
    feed(0, 1, 1'b0);
    wait_out("R4");
  endtask

  task automatic t_sat;
    for (int k = 0; k < 64; k++) xv[k] = (k % 2 == 1) ? 30000 : -32768;
    model(10, 64, 16);
    do_start(10, 64, 16);
    feed(0, 64, 1'b0);
    wait_out("R5");
    for (int k = 0; k < 64; k++) xv[k] = -32768;
    model(64, 64, 16);
    do_start(64, 64, 16);
    feed(0, 64, 1'b0);
    wait_out("R1");
  endtask

  task automatic t_rows;
    for (int k = 0; k < 12; k++) xv[k] = 400 - k * 70;
    model(33, 12, 5);
    do_start(33, 12, 5);
    feed(0, 12, 1'b0);
    wait_out("R7");
    model(33, 12, 0);
    do_start(33, 12, 0);
    feed(0, 12, 1'b0);
    wait_out("R7");
  endtask

  task automatic t_wrap;
    for (int k = 0; k < 20; k++) xv[k] = (k * 131) % 513 - 256;
    model(120, 20, 16);
    do_start(120, 20, 16);
    feed(0, 20, 1'b1);
    wait_out("R3");
  endtask

  task automatic t_b2b;
    for (int k = 0; k < 8; k++) xv[k] = 100 + k * 25;
    model(2, 8, 16);
    do_start(2, 8, 16);
    feed(0, 8, 1'b0);
    do_start(40, 6, 16);
    @(negedge clk);
    chk(out_valid == 1'b1, "R8", "first result with next start", out_valid, 1);
    chk(done == 1'b1, "R8", "first done with next start", done, 1);
    chk(in_ready == 1'b1, "R8", "next block ready at once", in_ready, 1);
    check_lanes("R8");
    @(posedge clk);
    #1;
    for (int k = 0; k < 6; k++) xv[k] = -200 + k * 90;
    model(40, 6, 16);
    feed(0, 6, 1'b0);
    wait_out("R8");
  endtask

  task automatic t_stall;
    out_ready = 1'b0;
    for (int k = 0; k < 10; k++) xv[k] = 350 - k * 60;
    model(77, 10, 16);
    do_start(77, 10, 16);
    feed(0, 10, 1'b0);
    @(negedge clk);
    @(negedge clk);
    chk(out_valid == 1'b1, "R9", "result present", out_valid, 1);
    do_start(90, 4, 16);
    for (int c = 0; c < 2; c++) begin
      @(negedge clk);
      chk(out_valid == 1'b1, "R9", "out_valid held", out_valid, 1);
      chk(in_ready == 1'b0, "R9", "in_ready low while stalled", in_ready, 0);
      check_lanes("R9");
    end
    out_ready = 1'b1;
    @(posedge clk);
    #1;
    for (int k = 0; k < 4; k++) xv[k] = 1000 - k * 500;
    model(90, 4, 16);
    feed(0, 4, 1'b0);
    wait_out("R9");
  endtask

  task automatic t_ignore;
    for (int k = 0; k < 8; k++) xv[k] = 50 * k - 170;
    model(3, 8, 16);
    do_start(3, 8, 16);
    feed(0, 3, 1'b0);
    @(negedge clk);
    start = 1'b1; base_addr = 7'd50; vec_len = 7'd2; row_cnt = 5'd1;
    @(posedge clk);
    #1 start = 1'b0;
    feed(3, 8, 1'b0);
    wait_out("R10");
    do_start(0, 0, 16);
    @(negedge clk);
    chk(busy == 1'b0, "R10", "zero length start ignored", busy, 0);
    chk(in_ready == 1'b0, "R10", "no ready after zero length", in_ready, 0);
    do_start(0, 65, 16);
    @(negedge clk);
    chk(busy == 1'b0, "R10", "length 65 start ignored", busy, 0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R10", "no result from ignored start", out_valid, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_basic();
    t_round();
    t_sat();
    t_rows();
    t_wrap();
    t_b2b();
    t_stall();
    t_ignore();
    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule